// File: doc/BRIEF.md
# Pin-Triggered Non-Volatile Store/Recall Controller

This block sits between four active-low control pins of a shadowed SRAM and the rest of the memory macro. These pins are non-volatile enable, chip enable, write enable and output enable. It decodes them into ordinary SRAM read and write grants. It also decides when to launch a store, which copies the SRAM into the non-volatile shadow, or a recall, which copies the shadow back into the SRAM. The arrays and the transfer timing sit in a separate transfer engine. That engine receives the start pulses from this block and reports completion through `xfer_done`.

A non-volatile cycle is launched only by a high-to-low transition of the non-volatile enable pin, and only while no cycle is running. Holding the pins in a store or recall pattern therefore never repeats a cycle. Leaving reset with the enable already low starts nothing. A supply-OK input blocks new stores and aborts a store already under way. While a cycle runs, the block gives no SRAM grant and keeps the data bus released. The pin inputs pass through `SYNC_STAGES` flip-flops before they are decoded.

Top module: `nvram_pin_ctrl`

## Requirements
- R1: With chip enable low, output enable low, and write enable and non-volatile enable high, and no cycle running, `sram_rd_grant` and `dq_oe` are 1 and `sram_wr_grant` is 0.
- R2: With chip enable and write enable low and non-volatile enable high, and no cycle running, `sram_wr_grant` is 1 and `dq_oe` is 0. With non-volatile enable low, no write grant is given.
- R3: With chip enable high, `sram_rd_grant`, `sram_wr_grant` and `dq_oe` are all 0.
- R4: A high-to-low transition of non-volatile enable while chip enable and write enable are low, output enable is high, supply-OK is 1 and no cycle is running gives a one-cycle `store_start` pulse. In the same cycle, `busy` rises.
- R5: A high-to-low transition of non-volatile enable while chip enable and output enable are low, write enable is high and no cycle is running gives a one-cycle `recall_start` pulse, and `busy` rises.
- R6: Holding the store pattern, with non-volatile enable still low, after a cycle completes starts no further cycle.
- R7: Leaving reset with non-volatile enable already low, in the store pattern, gives no start pulse.
- R8: While `busy` is 1, all grants and `dq_oe` are 0. A non-volatile enable transition that arrives during a cycle is discarded and is not replayed afterwards.
- R9: With supply-OK at 0, a transition in the store pattern gives no `store_start`, and `busy` stays 0.
- R10: If supply-OK drops during a store, `xfer_abort` pulses for one cycle. In that same cycle, `busy` returns to 0.
- R11: `xfer_done` during a cycle clears `busy` one clock later. In that clock, the read or write pattern present on the pins is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ne_n | input | 1 | Non-volatile enable pin, active low |
| ce_n | input | 1 | Chip enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| supply_ok | input | 1 | Supply above the safe threshold for a store |
| xfer_done | input | 1 | Transfer engine finished the running cycle |
| store_start | output | 1 | One-cycle pulse that launches a store |
| recall_start | output | 1 | One-cycle pulse that launches a recall |
| xfer_abort | output | 1 | One-cycle pulse that cancels a running store |
| busy | output | 1 | A non-volatile cycle is running |
| sram_rd_grant | output | 1 | SRAM read access granted |
| sram_wr_grant | output | 1 | SRAM write access granted |
| dq_oe | output | 1 | Drive the data bus |

## Verification
A pin change made between clock edges reaches the grants and `dq_oe` after `SYNC_STAGES` rising edges. A start pulse, and the rise of `busy`, appear one edge after that. `xfer_done` and `supply_ok` are not synchronised, so their effects on `busy` and `xfer_abort` are visible after a single edge. Every stimulus task reads the bench's edge counter and queues each expected value tagged with the exact edge count at which it is due. The monitor compares the outputs at the falling edge of that cycle. An expectation still queued once its cycle has passed counts as a failure.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

  // Bit positions inside the packed pin vector.
  localparam int PIN_NE = 3;
  localparam int PIN_CE = 2;
  localparam int PIN_WE = 1;
  localparam int PIN_OE = 0;
  localparam int PIN_W  = 4;

  // Reset image of the synchronised pins. NE resets low so that a pin that is
  // already low when reset ends is never seen as a falling edge.
  localparam logic [PIN_W-1:0] PIN_RST = 4'b0111;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RECALL = 2'd2
  } nvc_op_e;

  typedef struct packed {
    logic store_req;
    logic recall_req;
    logic rd_req;
    logic wr_req;
  } nvc_req_t;

endpackage

// File: rtl/nvc_pin_sync.sv
module nvc_pin_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = din;
      end else begin : g_next
        assign stage_d = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= stage_d;
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/nvc_fall_detect.sv
module nvc_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fall
);

  logic prev_q;
  logic prev_d;

  assign prev_d = level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign fall = prev_q & ~level;

endmodule

// File: rtl/nvc_mode_decode.sv
module nvc_mode_decode
  import nvc_pkg::*;
(
  input  logic [PIN_W-1:0] pins,
  output nvc_req_t         req
);

  logic ne, ce, we, oe;

  always_comb begin
    ne = ~pins[PIN_NE];
    ce = ~pins[PIN_CE];
    we = ~pins[PIN_WE];
    oe = ~pins[PIN_OE];
    req.store_req  = ne & ce & we & ~oe;
    req.recall_req = ne & ce & oe & ~we;
    req.rd_req     = ~ne & ce & oe & ~we;
    req.wr_req     = ~ne & ce & we;
  end

endmodule

// File: rtl/nvc_cycle_ctrl.sv
module nvc_cycle_ctrl
  import nvc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ne_fall,
  input  nvc_req_t req,
  input  logic     supply_ok,
  input  logic     xfer_done,
  output logic     store_start,
  output logic     recall_start,
  output logic     xfer_abort,
  output logic     busy
);

  nvc_op_e op_q, op_d;
  logic    store_d, recall_d, abort_d;

  always_comb begin
    op_d     = op_q;
    store_d  = 1'b0;
    recall_d = 1'b0;
    abort_d  = 1'b0;
    unique case (op_q)
      OP_IDLE: begin
        if (ne_fall && req.store_req && supply_ok) begin
          op_d    = OP_STORE;
          store_d = 1'b1;
        end else if (ne_fall && req.recall_req) begin
          op_d     = OP_RECALL;
          recall_d = 1'b1;
        end
      end
      OP_STORE: begin
        if (!supply_ok) begin
          op_d    = OP_IDLE;
          abort_d = 1'b1;
        end else if (xfer_done) begin
          op_d = OP_IDLE;
        end
      end
      OP_RECALL: begin
        if (xfer_done) op_d = OP_IDLE;
      end
      default: op_d = OP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q         <= OP_IDLE;
      store_start  <= 1'b0;
      recall_start <= 1'b0;
      xfer_abort   <= 1'b0;
    end else begin
      op_q         <= op_d;
      store_start  <= store_d;
      recall_start <= recall_d;
      xfer_abort   <= abort_d;
    end
  end

  assign busy = (op_q != OP_IDLE);

endmodule

// File: rtl/nvram_pin_ctrl.sv
module nvram_pin_ctrl
  import nvc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ne_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic supply_ok,
  input  logic xfer_done,
  output logic store_start,
  output logic recall_start,
  output logic xfer_abort,
  output logic busy,
  output logic sram_rd_grant,
  output logic sram_wr_grant,
  output logic dq_oe
);

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             ne_fall;
  nvc_req_t         req;

  always_comb begin
    pins_raw         = '0;
    pins_raw[PIN_NE] = ne_n;
    pins_raw[PIN_CE] = ce_n;
    pins_raw[PIN_WE] = we_n;
    pins_raw[PIN_OE] = oe_n;
  end

  nvc_pin_sync #(
    .STAGES  (SYNC_STAGES),
    .WIDTH   (PIN_W),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pins_raw),
    .dout  (pins_s)
  );

  nvc_fall_detect u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .level (pins_s[PIN_NE]),
    .fall  (ne_fall)
  );

  nvc_mode_decode u_dec (
    .pins (pins_s),
    .req  (req)
  );

  nvc_cycle_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ne_fall      (ne_fall),
    .req          (req),
    .supply_ok    (supply_ok),
    .xfer_done    (xfer_done),
    .store_start  (store_start),
    .recall_start (recall_start),
    .xfer_abort   (xfer_abort),
    .busy         (busy)
  );

  assign sram_rd_grant = req.rd_req & ~busy;
  assign sram_wr_grant = req.wr_req & ~busy;
  assign dq_oe         = sram_rd_grant;

endmodule

// File: rtl/nvc_checker.sv
module nvc_checker (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic store_start,
  input logic recall_start,
  input logic xfer_abort,
  input logic busy,
  input logic sram_rd_grant,
  input logic sram_wr_grant,
  input logic dq_oe
);

  AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_rd_grant && sram_wr_grant));                               // R2

  AST_STORE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> busy);                                            // R4

  AST_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_start && recall_start));                                  // R5

  AST_RECALL_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |-> busy);                                           // R5

  AST_STORE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |=> !store_start);                                    // R6

  AST_RECALL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |=> !recall_start);                                  // R6

  AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!sram_rd_grant && !sram_wr_grant && !dq_oe));           // R8

  AST_STORE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> $past(supply_ok));                                // R9

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> !busy);                                            // R10

  AST_ABORT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> $past(busy));                                      // R10

endmodule

bind nvram_pin_ctrl nvc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_ok     (supply_ok),
  .store_start   (store_start),
  .recall_start  (recall_start),
  .xfer_abort    (xfer_abort),
  .busy          (busy),
  .sram_rd_grant (sram_rd_grant),
  .sram_wr_grant (sram_wr_grant),
  .dq_oe         (dq_oe)
);

// File: tb/nvram_pin_ctrl_tb.sv
module nvram_pin_ctrl_tb;

  localparam int S = 2;

  typedef enum int {SG_STORE, SG_RECALL, SG_ABORT, SG_BUSY, SG_RD, SG_WR, SG_DQ} sig_e;
  typedef struct {
    int    due;
    sig_e  sig;
    bit    val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic ne_n, ce_n, we_n, oe_n, supply_ok, xfer_done;
  logic store_start, recall_start, xfer_abort, busy;
  logic sram_rd_grant, sram_wr_grant, dq_oe;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done_run = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvram_pin_ctrl #(.SYNC_STAGES(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .ne_n(ne_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .supply_ok(supply_ok), .xfer_done(xfer_done),
    .store_start(store_start), .recall_start(recall_start),
    .xfer_abort(xfer_abort), .busy(busy), .sram_rd_grant(sram_rd_grant),
    .sram_wr_grant(sram_wr_grant), .dq_oe(dq_oe)
  );

  function automatic bit sample(sig_e s);
    case (s)
      SG_STORE:  return store_start;
      SG_RECALL: return recall_start;
      SG_ABORT:  return xfer_abort;
      SG_BUSY:   return busy;
      SG_RD:     return sram_rd_grant;
      SG_WR:     return sram_wr_grant;
      default:   return dq_oe;
    endcase
  endfunction

  task automatic expect_at(int due, sig_e s, bit v, string tag);
    exp_t e;
    int   idx;
    e.due = due; e.sig = s; e.val = v; e.tag = tag;
    idx = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].due > due) begin idx = i; break; end
    end
    sb.insert(idx, e);
  endtask

  task automatic pins(bit ne, bit ce, bit we, bit oe);
    ne_n = ne; ce_n = ce; we_n = we; oe_n = oe;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expectations due in the current cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      bit   act;
      e = sb.pop_front();
      checks++;
      act = sample(e.sig);
      if (e.due < cyc) begin
        errors++;
        $display("FAIL %s: %s missed cycle %0d (actual %0b expected %0b)",
                 e.tag, e.sig.name(), e.due, act, e.val);
      end else if (act !== e.val) begin
        errors++;
        $display("FAIL %s: %s at cycle %0d actual %0b expected %0b",
                 e.tag, e.sig.name(), cyc, act, e.val);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung (actual running expected finished)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int m;
    rst_n = 1'b0; supply_ok = 1'b1; xfer_done = 1'b0;
    pins(1'b0, 1'b0, 1'b0, 1'b1);          // store pattern, NE already low
    tick(3);
    rst_n = 1'b1;
    n = cyc;
    expect_at(n, SG_BUSY, 1'b0, "R7_reset");
    expect_at(n, SG_DQ, 1'b0, "R7_reset");
    for (int k = 1; k <= 5; k++) begin
      expect_at(n + k, SG_STORE, 1'b0, "R7");
      expect_at(n + k, SG_BUSY, 1'b0, "R7");
    end
    tick(6);

    // R1 read
    pins(1'b1, 1'b0, 1'b1, 1'b0); n = cyc;
    expect_at(n + S, SG_RD, 1'b1, "R1");
    expect_at(n + S, SG_DQ, 1'b1, "R1");
    expect_at(n + S, SG_WR, 1'b0, "R1");
    tick(4);

    // R2 write
    pins(1'b1, 1'b0, 1'b0, 1'b1); n = cyc;
    expect_at(n + S, SG_WR, 1'b1, "R2");
    expect_at(n + S, SG_RD, 1'b0, "R2");
    expect_at(n + S, SG_DQ, 1'b0, "R2");
    tick(4);

    // R3 deselect
    pins(1'b1, 1'b1, 1'b0, 1'b0); n = cyc;
    expect_at(n + S, SG_WR, 1'b0, "R3");
    expect_at(n + S, SG_RD, 1'b0, "R3");
    expect_at(n + S, SG_DQ, 1'b0, "R3");
    tick(4);

    // R4 store on NE fall
    pins(1'b1, 1'b0, 1'b0, 1'b1); tick(4);
    pins(1'b0, 1'b0, 1'b0, 1'b1); n = cyc;
    expect_at(n + S, SG_WR, 1'b0, "R2_ne_low");
    expect_at(n + S, SG_STORE, 1'b0, "R4");
    expect_at(n + S + 1, SG_STORE, 1'b1, "R4");
    expect_at(n + S + 1, SG_BUSY, 1'b1, "R4");
    expect_at(n + S + 1, SG_RECALL, 1'b0, "R4");
    expect_at(n + S + 2, SG_STORE, 1'b0, "R4");
    expect_at(n + S + 2, SG_BUSY, 1'b1, "R8");
    tick(6);

    // R6 completion with store pattern held
    xfer_done = 1'b1; n = cyc; tick(1); xfer_done = 1'b0;
    expect_at(n + 1, SG_BUSY, 1'b0, "R11");
    expect_at(n + 1, SG_WR, 1'b0, "R6");
    for (int k = 1; k <= 4; k++) begin
      expect_at(n + k, SG_STORE, 1'b0, "R6");
      expect_at(n + k, SG_BUSY, 1'b0, "R6");
    end
    tick(5);

    // R5 recall
    pins(1'b1, 1'b0, 1'b1, 1'b0); tick(4);
    pins(1'b0, 1'b0, 1'b1, 1'b0); n = cyc;
    expect_at(n + S + 1, SG_RECALL, 1'b1, "R5");
    expect_at(n + S + 1, SG_BUSY, 1'b1, "R5");
    expect_at(n + S + 1, SG_STORE, 1'b0, "R5");
    expect_at(n + S + 1, SG_DQ, 1'b0, "R8");
    expect_at(n + S + 2, SG_RECALL, 1'b0, "R5");
    tick(5);

    // R8 edge during busy is discarded
    pins(1'b1, 1'b0, 1'b1, 1'b0); tick(3);
    pins(1'b0, 1'b0, 1'b1, 1'b0); n = cyc;
    expect_at(n + S + 1, SG_RECALL, 1'b0, "R8");
    expect_at(n + S + 1, SG_RD, 1'b0, "R8");
    tick(4);
    pins(1'b1, 1'b0, 1'b1, 1'b0); tick(3);

    // R11 completion with read pattern present
    xfer_done = 1'b1; n = cyc; tick(1); xfer_done = 1'b0;
    expect_at(n + 1, SG_BUSY, 1'b0, "R11");
    expect_at(n + 1, SG_RD, 1'b1, "R11");
    expect_at(n + 1, SG_DQ, 1'b1, "R11");
    expect_at(n + 2, SG_RECALL, 1'b0, "R8_no_replay");
    expect_at(n + 3, SG_RECALL, 1'b0, "R8_no_replay");
    tick(4);

    // R9 supply guard
    pins(1'b1, 1'b0, 1'b0, 1'b1); supply_ok = 1'b0; tick(4);
    pins(1'b0, 1'b0, 1'b0, 1'b1); n = cyc;
    expect_at(n + S + 1, SG_STORE, 1'b0, "R9");
    expect_at(n + S + 1, SG_BUSY, 1'b0, "R9");
    tick(5);

    // R10 abort
    pins(1'b1, 1'b0, 1'b0, 1'b1); supply_ok = 1'b1; tick(4);
    pins(1'b0, 1'b0, 1'b0, 1'b1); n = cyc;
    expect_at(n + S + 1, SG_STORE, 1'b1, "R4");
    tick(S + 3);
    supply_ok = 1'b0; m = cyc;
    expect_at(m, SG_BUSY, 1'b1, "R10");
    expect_at(m + 1, SG_ABORT, 1'b1, "R10");
    expect_at(m + 1, SG_BUSY, 1'b0, "R10");
    expect_at(m + 2, SG_ABORT, 1'b0, "R10");
    tick(4);

    while (sb.size() > 0) tick(1);
    done_run = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule